// File: doc/BRIEF.md
# Gated Non-Retriggerable One-Shot Pulse Generator

This block produces exactly one output pulse, counted in clock cycles, each time a gated trigger condition is met on its three control inputs. It has a falling-edge trigger input, a rising-edge trigger input and an active-low clear. Each input can act as an inhibit for the others. All three inputs may arrive asynchronously. They are brought into the clock domain inside the block, and their edges are judged from synchronized samples. The pulse length comes from a cycle-count input, which is captured when the trigger is accepted. A down-counter times the pulse. The block drives the pulse and its complement.

A pulse can start in three ways: the rising-edge input goes high while the falling-edge input is low; the falling-edge input goes low while the rising-edge input is high; or the clear is released while the trigger levels already form a valid condition. The third path works only when an internal arming flag is set. The flag is set by any idle level (falling-edge input high or rising-edge input low) while the clear is released, and it is dropped whenever a trigger is accepted. Once a pulse is running, the trigger inputs are ignored. Taking the clear low ends a running pulse early.

Top module: `gated_oneshot`

## Requirements
- R1: During reset and after its release, pulse_o is 0 and pulse_n_o is 1. Static input levels present across reset release never start a pulse.
- R2: trig_rise_i going 0 to 1 while trig_fall_i is 0 and clr_n_i is 1 starts a pulse. pulse_o rises on the third rising clock edge after the input change.
- R3: trig_fall_i going 1 to 0 while trig_rise_i is 1 and clr_n_i is 1 starts a pulse, with the same latency as R2.
- R4: clr_n_i going 0 to 1 while trig_fall_i is 0, trig_rise_i is 1 and the arming flag is set starts a pulse.
- R5: The arming flag is set in any cycle where clr_n_i is 1 and either trig_fall_i is 1 or trig_rise_i is 0. It is cleared by every accepted trigger, including one with width 0. A clear release while the flag is clear starts no pulse.
- R6: pulse_o stays high for exactly width_i cycles, using the value sampled in the trigger cycle. This holds however long the trigger input stays asserted, and later changes of width_i have no effect on the running pulse.
- R7: An accepted trigger with width_i equal to 0 produces no pulse.
- R8: While a pulse runs, edges on trig_fall_i and trig_rise_i neither restart nor extend it.
- R9: clr_n_i going low ends a running pulse. pulse_o falls on the third rising edge after the change.
- R10: pulse_n_o is always the inverse of pulse_o.
- R11: No pulse starts from any of these: a rise of trig_rise_i while trig_fall_i is 1; a fall of trig_fall_i while trig_rise_i is 0; or a trigger-input edge while clr_n_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_fall_i | input | 1 | Trigger input that fires on its falling edge, asynchronous |
| trig_rise_i | input | 1 | Trigger input that fires on its rising edge, asynchronous |
| clr_n_i | input | 1 | Active-low overriding clear; its release is a third trigger |
| width_i | input | WIDTH_W | Pulse length in clock cycles, sampled on trigger |
| pulse_o | output | 1 | One-shot output, high during the pulse |
| pulse_n_o | output | 1 | Complement of pulse_o |

## Verification
Each of the three trigger paths is fired from a known idle state. The mirror-image patterns are also applied, such as a rise with the wrong gate level or an edge while the clear is low. This separates correct gating from a block that simply reacts to any edge. Short and long trigger assertions, and a width change during the pulse, separate a length sampled at trigger time from one that follows the inputs. A clear release is tried with the arming flag both set and cleared (the cleared case follows a zero-width trigger or a truncated pulse), which shows whether the flag is set and dropped at the right moments. Extra edges inside a running pulse and an early clear show whether the block is non-retriggerable and whether the clear overrides it.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Synchronized control levels as seen by the trigger logic
  typedef struct packed {
    logic clr_n;  // overriding clear, active low
    logic rise;   // rising-edge trigger input
    logic fall;   // falling-edge trigger input
  } lvl_t;

  localparam int unsigned LVL_W = $bits(lvl_t);

endpackage

// File: rtl/os_sync.sv
// Multi-stage flop chain bringing W asynchronous bits into the clock domain
module os_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  if (STAGES == 1) begin : g_single
    always_comb chain_d = din_i;
  end else begin : g_multi
    always_comb chain_d = {chain_q[STAGES-2:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign dout_o = chain_q[STAGES-1];

endmodule

// File: rtl/os_trigger.sv
// Edge detection, trigger gating and arming flag
module os_trigger
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic warm_i,   // synchronized samples are valid
  input  lvl_t lvl_i,    // synchronized levels
  input  logic busy_i,   // pulse running
  output logic fire_o
);

  lvl_t prev_q;
  logic arm_q, arm_d, arm_en;
  logic edge_rise, edge_fall, edge_rel;
  logic hit_rise, hit_fall, hit_rel;
  logic gate_open;

  always_comb begin
    edge_rise = lvl_i.rise & ~prev_q.rise;
    edge_fall = ~lvl_i.fall & prev_q.fall;
    edge_rel  = lvl_i.clr_n & ~prev_q.clr_n;
    gate_open = ~lvl_i.fall & lvl_i.rise;

    hit_rise = edge_rise & ~lvl_i.fall & lvl_i.clr_n;
    hit_fall = edge_fall & lvl_i.rise & lvl_i.clr_n;
    hit_rel  = edge_rel & gate_open & arm_q;

    fire_o = warm_i & ~busy_i & (hit_rise | hit_fall | hit_rel);
  end

  // arming flag next state: an accepted trigger wins over a set
  always_comb begin
    arm_en = 1'b0;
    arm_d  = arm_q;
    if (fire_o) begin
      arm_en = 1'b1;
      arm_d  = 1'b0;
    end else if (warm_i && lvl_i.clr_n && !gate_open) begin
      arm_en = 1'b1;
      arm_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (arm_en) arm_q <= arm_d;
    end
  end

  // R5
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fire_o |=> !arm_q);

  // R11
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!lvl_i.clr_n || !$past(lvl_i.clr_n) && !arm_q) |-> !fire_o || !edge_rel);

endmodule

// File: rtl/os_timer.sv
// Pulse length counter and output registers
module os_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             clr_n_i,   // synchronized clear level
  input  logic [CNT_W-1:0] width_i,
  output logic             busy_o,
  output logic             pulse_o,
  output logic             pulse_n_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             pulse_q, pulse_d;
  logic             pulse_n_q, pulse_n_d;

  assign busy_o = (cnt_q != '0);

  always_comb begin
    cnt_en = !clr_n_i || fire_i || busy_o;
    if (!clr_n_i)    cnt_d = '0;
    else if (fire_i) cnt_d = width_i;
    else if (busy_o) cnt_d = cnt_q - CNT_W'(1);
    else             cnt_d = cnt_q;
    pulse_d   = (cnt_d != '0);
    pulse_n_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pulse_q   <= 1'b0;
      pulse_n_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q     <= cnt_d;
      pulse_q   <= pulse_d;
      pulse_n_q <= pulse_n_d;
    end
  end

  assign pulse_o   = pulse_q;
  assign pulse_n_o = pulse_n_q;

  // R10
  out_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    pulse_q != pulse_n_q);

  // R9
  clr_cut_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !clr_n_i |=> !pulse_q);

  // R7
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire_i && width_i == '0) |=> !pulse_q);

  // R8
  no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && clr_n_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/gated_oneshot.sv
module gated_oneshot
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_fall_i,
  input  logic               trig_rise_i,
  input  logic               clr_n_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_o,
  output logic               pulse_n_o
);

  localparam int unsigned WARM_CYC = SYNC_STAGES + 1;
  localparam int unsigned WARM_W   = $clog2(WARM_CYC + 1);

  logic             rst_int_n;
  lvl_t             lvl_raw, lvl_sync;
  logic [LVL_W-1:0] lvl_sync_bits;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic             warm, warm_en;
  logic             fire, busy;

  // reset: asynchronous assert, synchronous release
  os_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .din_i  (1'b1),
    .dout_o (rst_int_n)
  );

  always_comb begin
    lvl_raw.clr_n = clr_n_i;
    lvl_raw.rise  = trig_rise_i;
    lvl_raw.fall  = trig_fall_i;
  end

  os_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .din_i  (lvl_raw),
    .dout_o (lvl_sync_bits)
  );
  assign lvl_sync = lvl_t'(lvl_sync_bits);

  // warm-up: hold off edge judgement until chain and history are filled
  always_comb begin
    warm    = (warm_q == WARM_W'(WARM_CYC));
    warm_en = !warm;
    warm_d  = warm_q + WARM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   warm_q <= '0;
    else if (warm_en) warm_q <= warm_d;
  end

  os_trigger u_trig (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .warm_i (warm),
    .lvl_i  (lvl_sync),
    .busy_i (busy),
    .fire_o (fire)
  );

  os_timer #(.CNT_W(WIDTH_W)) u_timer (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .fire_i    (fire),
    .clr_n_i   (lvl_sync.clr_n),
    .width_i   (width_i),
    .busy_o    (busy),
    .pulse_o   (pulse_o),
    .pulse_n_o (pulse_n_o)
  );

  // R1
  warm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !warm |=> !pulse_o);

endmodule

// File: tb/gated_oneshot_tb_top.sv
`timescale 1ns/1ps
module gated_oneshot_tb_top;

  localparam int unsigned WW = 16;

  logic          clk;
  logic          rst_n;
  logic          trig_fall_i, trig_rise_i, clr_n_i;
  logic [WW-1:0] width_i;
  logic          pulse_o, pulse_n_o;

  int    n_checks;
  int    n_fail;
  int    exp_q[$];
  int    run_len;
  bit    run_mon;
  bit    done;
  string cur_req;

  gated_oneshot #(.WIDTH_W(WW), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_fall_i (trig_fall_i),
    .trig_rise_i (trig_rise_i),
    .clr_n_i     (clr_n_i),
    .width_i     (width_i),
    .pulse_o     (pulse_o),
    .pulse_n_o   (pulse_n_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic fail(input string req, input int act, input int exp);
    n_fail++;
    $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic a, input logic b, input logic c);
    @(negedge clk);
    trig_fall_i = a;
    trig_rise_i = b;
    clr_n_i     = c;
  endtask

  task automatic expect_pulse(input int len);
    exp_q.push_back(len);
  endtask

  task automatic end_scenario(input string req);
    n_checks++;
    if (exp_q.size() != 0 || run_len != 0)
      fail(req, exp_q.size() + run_len, 0);
  endtask

  // monitor: measures pulses at falling edges and compares with the queue
  always @(negedge clk) begin
    if (run_mon) begin
      n_checks++;
      if (pulse_o == pulse_n_o) fail("R10", int'(pulse_n_o), int'(!pulse_o));
      if (pulse_o) run_len++;
      else if (run_len != 0) begin
        n_checks++;
        if (exp_q.size() == 0) fail({cur_req, " unexpected pulse"}, run_len, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          if (e != run_len) fail(cur_req, run_len, e);
        end
        run_len = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; run_len = 0; run_mon = 0; done = 0;
    cur_req = "R1";
    rst_n = 1'b0;
    trig_fall_i = 1'b0; trig_rise_i = 1'b1; clr_n_i = 1'b1;
    width_i = WW'(5);
    wait_n(4);
    // R1: reset state
    n_checks++; if (pulse_o !== 1'b0) fail("R1", int'(pulse_o), 0);
    n_checks++; if (pulse_n_o !== 1'b1) fail("R1", int'(pulse_n_o), 1);
    rst_n = 1'b1;
    run_mon = 1;
    wait_n(20);
    end_scenario("R1");
    drive(1, 1, 1); drive(1, 0, 1); wait_n(5);

    // R2 with R11 inhibit on the way
    cur_req = "R11"; width_i = WW'(5);
    drive(0, 0, 1); wait_n(8); end_scenario("R11");
    cur_req = "R2"; expect_pulse(5);
    drive(0, 1, 1); wait_n(20); end_scenario("R2");
    drive(0, 0, 1); drive(1, 0, 1); wait_n(5);

    // R3 with R11 inhibit on the way
    cur_req = "R11"; width_i = WW'(7);
    drive(1, 1, 1); wait_n(8); end_scenario("R11");
    cur_req = "R3"; expect_pulse(7);
    drive(0, 1, 1); wait_n(20); end_scenario("R3");
    drive(1, 1, 1); drive(1, 0, 1); wait_n(5);

    // R6: short trigger, long trigger, width change during pulse
    cur_req = "R6"; width_i = WW'(4);
    drive(0, 0, 1); wait_n(8);
    expect_pulse(4);
    drive(0, 1, 1); drive(0, 0, 1); wait_n(20); end_scenario("R6");
    width_i = WW'(3); expect_pulse(3);
    drive(0, 1, 1); wait_n(5); width_i = WW'(9); wait_n(20); end_scenario("R6");
    drive(0, 0, 1); drive(1, 0, 1); wait_n(5);

    // R7: zero width, then R5 clear release without arming
    cur_req = "R7"; width_i = WW'(0);
    drive(0, 0, 1); wait_n(8);
    drive(0, 1, 1); wait_n(20); end_scenario("R7");
    cur_req = "R5";
    drive(0, 1, 0); wait_n(8);
    drive(0, 1, 1); wait_n(20); end_scenario("R5");
    // arm via trig_fall high with clear released, then R4 trigger
    cur_req = "R11";
    drive(0, 1, 0); wait_n(5);
    drive(1, 1, 0); wait_n(5);
    drive(1, 1, 1); wait_n(8); end_scenario("R11");
    drive(1, 1, 0); wait_n(5);
    drive(0, 1, 0); wait_n(8); end_scenario("R11");
    cur_req = "R4"; width_i = WW'(6); expect_pulse(6);
    drive(0, 1, 1); wait_n(20); end_scenario("R4");
    drive(1, 1, 1); drive(1, 0, 1); wait_n(5);

    // R8: extra edges inside a running pulse
    cur_req = "R8"; width_i = WW'(10);
    drive(0, 0, 1); wait_n(8);
    expect_pulse(10);
    drive(0, 1, 1); wait_n(2);
    drive(0, 0, 1); wait_n(1);
    drive(0, 1, 1); wait_n(1);
    drive(1, 1, 1);
    drive(0, 1, 1); wait_n(25); end_scenario("R8");
    drive(0, 0, 1); drive(1, 0, 1); wait_n(5);

    // R9: clear cuts the pulse after 6 cycles; release unarmed (R5)
    cur_req = "R9"; width_i = WW'(20);
    drive(0, 0, 1); wait_n(8);
    expect_pulse(6);
    drive(0, 1, 1); wait_n(5);
    drive(0, 1, 0); wait_n(10);
    drive(0, 1, 1); wait_n(25); end_scenario("R9");
    drive(0, 0, 1); drive(1, 0, 1); wait_n(5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule